// File: doc/BRIEF.md
# Shadowed Real-Time Clock with Alarm Interrupts

The block is a real-time clock peripheral behind a small memory-mapped register port. A running time base counts sub-ticks of a 32 kHz enable into milliseconds (0 to MS_PER_SEC-1) and milliseconds into a 32-bit seconds count. Software never sees the running counters directly. Once every POST_TICKS ticks the block opens a copy window. A busy flag is high for BUSY_CYCLES bus clocks, and on the last cycle of the window the running seconds and milliseconds are posted to bus-visible registers.

A read of the posted milliseconds register latches the posted seconds into a shadow register on the same clock edge, so software reads milliseconds first and then the shadow to get a coherent pair. Two seconds alarms and one milliseconds alarm compare against the running counters. Each raises a status bit, and a maskable level-high interrupt is driven from the status and mask registers. Status is cleared by writing ones. Writes are accepted only while busy is low; a rejected write leaves every register unchanged and sets a sticky reject flag.

Top module: `rtc_shadow`

## Requirements
- R1: On each `tick_32k` pulse a sub-tick counter advances; after TICKS_PER_MS ticks the running milliseconds advance, and when milliseconds pass MS_PER_SEC-1 they return to 0 and the running seconds increase by one.
- R2: Every POST_TICKS ticks the busy bit (bit 0 at offset 0x004) goes high for exactly BUSY_CYCLES clocks; on its last cycle the running values are copied to the posted seconds (0x008) and posted milliseconds (0x010), which change at no other time.
- R3: A read of 0x010 copies the posted seconds into the shadow register (0x00C) on the same edge, so a following read of 0x00C returns the seconds that belong with the milliseconds just read.
- R4: An accepted write to 0x008 loads the running seconds counter with the write data on the next edge; this takes precedence over an increment on the same edge.
- R5: Any write issued while busy is 1 changes no register and sets `wr_reject`, which then stays 1 until reset.
- R6: Alarm 0 (0x014, status/mask bit 0) sets its status bit on every tick where the running seconds equal a nonzero alarm value; a value of 0 disables it.
- R7: Alarm 1 (0x018, status/mask bit 1) behaves like alarm 0 with its own compare value.
- R8: The milliseconds alarm (0x01C, low bits; status/mask bit 2) sets its status bit on a tick where the running milliseconds equal its nonzero value.
- R9: Writing ones to the status register (0x02C) clears those bits; writing all ones clears every bit; a set on the same edge wins over a clear.
- R10: `irq` is high exactly while some status bit and its mask bit (0x028) are both 1; with the mask all zero it stays low.
- R11: The mask register holds five writable bits [4:0] that read back as written; status bits 3 and 4 always read 0.
- R12: After reset every register reads 0, `irq` and `wr_reject` are 0, and busy is 0.
- R13: Read data appears on `bus_rdata` one clock after the request and holds until the next read; writes to read-only offsets (0x004, 0x00C, 0x010) have no effect and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | One-cycle enable at the 32 kHz rate |
| bus_en | input | 1 | Register access request for this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after a read |
| irq | output | 1 | Level-high interrupt |
| wr_reject | output | 1 | Sticky flag: a write arrived while busy |

## Verification
The assertions take for granted that `tick_32k` pulses are single cycles spaced so that POST_TICKS ticks span more clocks than BUSY_CYCLES, so one copy window always closes before the next opens, and that each bus request lasts one cycle. The stimulus issues a tick every third clock with a window of four clocks in a 24-clock period. Ordinary writes wait for a cycle in which the reference model shows busy low, and one deliberate write is aimed inside a window to exercise rejection.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int NUM_IRQ  = 5;
    localparam int NUM_LIVE = 3;

    typedef enum logic [ADDR_W-1:0] {
        OFF_BUSY   = 8'h04,
        OFF_SEC    = 8'h08,
        OFF_SHADOW = 8'h0C,
        OFF_MS     = 8'h10,
        OFF_AL0    = 8'h14,
        OFF_AL1    = 8'h18,
        OFF_MSAL   = 8'h1C,
        OFF_MASK   = 8'h28,
        OFF_STS    = 8'h2C
    } reg_off_e;

    typedef enum int {
        IRQ_SEC_A0  = 0,
        IRQ_SEC_A1  = 1,
        IRQ_MS_A    = 2,
        IRQ_SEC_CD  = 3,
        IRQ_MS_CD   = 4
    } irq_bit_e;

    typedef struct packed {
        logic              en;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic logic alarm_hit(input logic [DATA_W-1:0] alarm_val,
                                       input logic [DATA_W-1:0] cur_val);
        return (alarm_val != '0) && (alarm_val == cur_val);
    endfunction

endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_shadow_pkg::*;
#(
    parameter int TICKS_PER_MS = 32,
    parameter int MS_PER_SEC   = 1000,
    parameter int MS_W         = $clog2(MS_PER_SEC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] run_sec,
    output logic [MS_W-1:0]   run_ms
);
    localparam int SUB_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;

    logic [SUB_W-1:0] sub_q;
    logic             ms_step;
    logic             sec_step;

    assign ms_step  = tick && (sub_q == SUB_W'(TICKS_PER_MS - 1));
    assign sec_step = ms_step && (run_ms == MS_W'(MS_PER_SEC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q   <= '0;
            run_ms  <= '0;
            run_sec <= '0;
        end else begin
            if (tick) begin
                sub_q <= ms_step ? '0 : sub_q + 1'b1;
            end
            if (ms_step) begin
                run_ms <= sec_step ? '0 : run_ms + 1'b1;
            end
            if (load_en) begin
                run_sec <= load_val;
            end else if (sec_step) begin
                run_sec <= run_sec + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rtc_post_ctrl.sv
module rtc_post_ctrl
    import rtc_shadow_pkg::*;
#(
    parameter int POST_TICKS  = 8,
    parameter int BUSY_CYCLES = 4,
    parameter int MS_W        = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [DATA_W-1:0] run_sec,
    input  logic [MS_W-1:0]   run_ms,
    output logic              busy,
    output logic [DATA_W-1:0] post_sec,
    output logic [MS_W-1:0]   post_ms
);
    localparam int PC_W = (POST_TICKS > 1) ? $clog2(POST_TICKS) : 1;
    localparam int BC_W = $clog2(BUSY_CYCLES + 1);

    logic [PC_W-1:0] pc_q;
    logic [BC_W-1:0] bcnt_q;
    logic            win_open;
    logic            win_last;

    assign win_open = tick && (pc_q == PC_W'(POST_TICKS - 1));
    assign win_last = (bcnt_q == BC_W'(1));
    assign busy     = (bcnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            bcnt_q   <= '0;
            post_sec <= '0;
            post_ms  <= '0;
        end else begin
            if (tick) begin
                pc_q <= win_open ? '0 : pc_q + 1'b1;
            end
            if (win_open) begin
                bcnt_q <= BC_W'(BUSY_CYCLES);
            end else if (busy) begin
                bcnt_q <= bcnt_q - 1'b1;
            end
            if (win_last) begin
                post_sec <= run_sec;
                post_ms  <= run_ms;
            end
        end
    end

endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
    import rtc_shadow_pkg::*;
#(
    parameter int MS_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic [DATA_W-1:0]   run_sec,
    input  logic [MS_W-1:0]     run_ms,
    input  logic [DATA_W-1:0]   alarm0,
    input  logic [DATA_W-1:0]   alarm1,
    input  logic [MS_W-1:0]     ms_alarm,
    input  logic                mask_we,
    input  logic [NUM_IRQ-1:0]  mask_wdata,
    input  logic                clr_we,
    input  logic [NUM_LIVE-1:0] clr_bits,
    output logic [NUM_IRQ-1:0]  status,
    output logic [NUM_IRQ-1:0]  mask,
    output logic                irq
);
    logic [NUM_LIVE-1:0] hit;
    logic [NUM_LIVE-1:0] live_q;

    for (genvar i = 0; i < NUM_LIVE; i++) begin : g_src
        if (i == IRQ_SEC_A0) begin : g_a0
            assign hit[i] = alarm_hit(alarm0, run_sec);
        end else if (i == IRQ_SEC_A1) begin : g_a1
            assign hit[i] = alarm_hit(alarm1, run_sec);
        end else begin : g_ms
            assign hit[i] = alarm_hit(DATA_W'(ms_alarm), DATA_W'(run_ms));
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                live_q[i] <= 1'b0;
            end else begin
                live_q[i] <= (live_q[i] & ~(clr_we & clr_bits[i])) | (tick & hit[i]);
            end
        end
    end

    assign status = NUM_IRQ'(live_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (mask_we) begin
            mask <= mask_wdata;
        end
    end

    assign irq = |(status & mask);

endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
    import rtc_shadow_pkg::*;
#(
    parameter int TICKS_PER_MS = 32,
    parameter int MS_PER_SEC   = 1000,
    parameter int POST_TICKS   = 8,
    parameter int BUSY_CYCLES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_32k,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              wr_reject
);
    localparam int MS_W = $clog2(MS_PER_SEC + 1);

    bus_req_t          req;
    logic              busy;
    logic [DATA_W-1:0] run_sec;
    logic [MS_W-1:0]   run_ms;
    logic [DATA_W-1:0] post_sec;
    logic [MS_W-1:0]   post_ms;
    logic [DATA_W-1:0] shadow_q;
    logic [DATA_W-1:0] alarm0_q;
    logic [DATA_W-1:0] alarm1_q;
    logic [MS_W-1:0]   msal_q;
    logic [NUM_IRQ-1:0] status;
    logic [NUM_IRQ-1:0] mask;
    logic              wr_ok;
    logic              wr_bad;
    logic              rd_go;
    logic              sec_load;
    logic              mask_we;
    logic              clr_we;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;
    logic              rej_q;

    assign req = '{en: bus_en, wr: bus_wr, addr: bus_addr, data: bus_wdata};

    assign wr_ok    = req.en && req.wr && !busy;
    assign wr_bad   = req.en && req.wr && busy;
    assign rd_go    = req.en && !req.wr;
    assign sec_load = wr_ok && (req.addr == OFF_SEC);
    assign mask_we  = wr_ok && (req.addr == OFF_MASK);
    assign clr_we   = wr_ok && (req.addr == OFF_STS);

    rtc_time_core #(
        .TICKS_PER_MS (TICKS_PER_MS),
        .MS_PER_SEC   (MS_PER_SEC),
        .MS_W         (MS_W)
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_32k),
        .load_en  (sec_load),
        .load_val (req.data),
        .run_sec  (run_sec),
        .run_ms   (run_ms)
    );

    rtc_post_ctrl #(
        .POST_TICKS  (POST_TICKS),
        .BUSY_CYCLES (BUSY_CYCLES),
        .MS_W        (MS_W)
    ) u_post (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_32k),
        .run_sec  (run_sec),
        .run_ms   (run_ms),
        .busy     (busy),
        .post_sec (post_sec),
        .post_ms  (post_ms)
    );

    rtc_irq_unit #(
        .MS_W (MS_W)
    ) u_irq (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_32k),
        .run_sec    (run_sec),
        .run_ms     (run_ms),
        .alarm0     (alarm0_q),
        .alarm1     (alarm1_q),
        .ms_alarm   (msal_q),
        .mask_we    (mask_we),
        .mask_wdata (req.data[NUM_IRQ-1:0]),
        .clr_we     (clr_we),
        .clr_bits   (req.data[NUM_LIVE-1:0]),
        .status     (status),
        .mask       (mask),
        .irq        (irq)
    );

    always_comb begin
        case (req.addr)
            OFF_BUSY:   rd_mux = DATA_W'(busy);
            OFF_SEC:    rd_mux = post_sec;
            OFF_SHADOW: rd_mux = shadow_q;
            OFF_MS:     rd_mux = DATA_W'(post_ms);
            OFF_AL0:    rd_mux = alarm0_q;
            OFF_AL1:    rd_mux = alarm1_q;
            OFF_MSAL:   rd_mux = DATA_W'(msal_q);
            OFF_MASK:   rd_mux = DATA_W'(mask);
            OFF_STS:    rd_mux = DATA_W'(status);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            shadow_q <= '0;
            alarm0_q <= '0;
            alarm1_q <= '0;
            msal_q   <= '0;
            rej_q    <= 1'b0;
        end else begin
            if (rd_go) begin
                rdata_q <= rd_mux;
                if (req.addr == OFF_MS) begin
                    shadow_q <= post_sec;
                end
            end
            if (wr_bad) begin
                rej_q <= 1'b1;
            end
            if (wr_ok) begin
                case (req.addr)
                    OFF_AL0:  alarm0_q <= req.data;
                    OFF_AL1:  alarm1_q <= req.data;
                    OFF_MSAL: msal_q   <= req.data[MS_W-1:0];
                    default:  ;
                endcase
            end
        end
    end

    assign bus_rdata = rdata_q;
    assign wr_reject = rej_q;

endmodule

// File: rtl/rtc_shadow_chk.sv
module rtc_shadow_chk
    import rtc_shadow_pkg::*;
#(
    parameter int MS_W       = 10,
    parameter int MS_PER_SEC = 1000
) (
    input logic               clk,
    input logic               rst,
    input logic               tick,
    input logic               bus_en,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               busy,
    input logic [DATA_W-1:0]  post_sec,
    input logic [MS_W-1:0]    post_ms,
    input logic [DATA_W-1:0]  shadow,
    input logic [DATA_W-1:0]  run_sec,
    input logic [MS_W-1:0]    run_ms,
    input logic [NUM_IRQ-1:0] status,
    input logic [NUM_IRQ-1:0] mask,
    input logic               irq,
    input logic               wr_reject
);
    a_r1_ms_in_range: assert property (@(posedge clk) disable iff (rst)
        run_ms < MS_W'(MS_PER_SEC));

    a_r2_post_at_window_end: assert property (@(posedge clk) disable iff (rst)
        (!$stable(post_sec) || !$stable(post_ms)) |-> $fell(busy));

    a_r3_shadow_from_ms_read: assert property (@(posedge clk) disable iff (rst)
        !$stable(shadow) |-> $past(bus_en && !bus_wr && bus_addr == OFF_MS));

    a_r4_sec_load: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_wr && !busy && bus_addr == OFF_SEC) |=> run_sec == $past(bus_wdata));

    a_r5_busy_write_flagged: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_wr && busy) |=> wr_reject);

    a_r5_reject_sticky: assert property (@(posedge clk) disable iff (rst)
        wr_reject |=> wr_reject);

    a_r9_clear_all: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_wr && !busy && bus_addr == OFF_STS && bus_wdata == '1 && !tick)
        |=> status == '0);

    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq);

endmodule

bind rtc_shadow rtc_shadow_chk #(
    .MS_W       (MS_W),
    .MS_PER_SEC (MS_PER_SEC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_32k),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .busy      (busy),
    .post_sec  (post_sec),
    .post_ms   (post_ms),
    .shadow    (shadow_q),
    .run_sec   (run_sec),
    .run_ms    (run_ms),
    .status    (status),
    .mask      (mask),
    .irq       (irq),
    .wr_reject (wr_reject)
);

// File: tb/rtc_shadow_test.sv
module rtc_shadow_test;

    localparam int TPM = 2;
    localparam int MPS = 10;
    localparam int PT  = 8;
    localparam int BC  = 4;
    localparam int GAP = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        en = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        rej;

    always #4 clk = ~clk;

    rtc_shadow #(
        .TICKS_PER_MS (TPM),
        .MS_PER_SEC   (MPS),
        .POST_TICKS   (PT),
        .BUSY_CYCLES  (BC)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .tick_32k  (tick),
        .bus_en    (en),
        .bus_wr    (wr),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq       (irq),
        .wr_reject (rej)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_sub, m_ms, m_pc, m_bcnt;
    logic [31:0] m_sec, m_psec, m_pms, m_shadow, m_a0, m_a1, m_msal, m_rdata;
    logic [4:0]  m_mask, m_status;
    bit          m_err;

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h04: return (m_bcnt != 0) ? 32'd1 : 32'd0;
            8'h08: return m_psec;
            8'h0C: return m_shadow;
            8'h10: return m_pms;
            8'h14: return m_a0;
            8'h18: return m_a1;
            8'h1C: return m_msal;
            8'h28: return {27'd0, m_mask};
            8'h2C: return {27'd0, m_status};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [4:0]  hit;
        logic [4:0]  clr;
        bit          busy_o;
        logic [31:0] o_sec;
        int          o_ms;
        if (rst) begin
            m_sub = 0; m_ms = 0; m_pc = 0; m_bcnt = 0;
            m_sec = 0; m_psec = 0; m_pms = 0; m_shadow = 0;
            m_a0 = 0; m_a1 = 0; m_msal = 0; m_rdata = 0;
            m_mask = 0; m_status = 0; m_err = 0;
        end else begin
            busy_o = (m_bcnt != 0);
            o_sec  = m_sec;
            o_ms   = m_ms;
            hit    = '0;
            clr    = '0;
            if (m_a0 != 0 && m_a0 == o_sec) hit[0] = 1'b1;
            if (m_a1 != 0 && m_a1 == o_sec) hit[1] = 1'b1;
            if (m_msal != 0 && m_msal == o_ms) hit[2] = 1'b1;
            if (en && !wr) begin
                m_rdata = m_read(addr);
                if (addr == 8'h10) m_shadow = m_psec;
            end
            if (m_bcnt == 1) begin
                m_psec = o_sec;
                m_pms  = o_ms;
            end
            if (tick && m_pc == PT - 1) m_bcnt = BC;
            else if (m_bcnt != 0) m_bcnt--;
            if (tick) m_pc = (m_pc + 1) % PT;
            if (tick) begin
                if (m_sub == TPM - 1) begin
                    m_sub = 0;
                    if (m_ms == MPS - 1) begin
                        m_ms = 0;
                        m_sec++;
                    end else m_ms++;
                end else m_sub++;
            end
            if (en && wr && busy_o) m_err = 1;
            if (en && wr && !busy_o) begin
                case (addr)
                    8'h08: m_sec  = wdata;
                    8'h14: m_a0   = wdata;
                    8'h18: m_a1   = wdata;
                    8'h1C: m_msal = wdata & 32'hF;
                    8'h28: m_mask = wdata[4:0];
                    8'h2C: clr    = wdata[4:0];
                    default: ;
                endcase
            end
            m_status = (m_status & ~clr) | (tick ? hit : 5'd0);
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R13 rdata vs model", rdata, m_rdata);
            check("R10 irq vs model", {31'd0, irq}, ((m_status & m_mask) != 0) ? 32'd1 : 32'd0);
            check("R5 wr_reject vs model", {31'd0, rej}, m_err ? 32'd1 : 32'd0);
        end
    end

    // tick generator
    bit tick_on = 1;
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            tick = tick_on && !rst && (cnt == 0);
            cnt  = (cnt + 1) % GAP;
        end
    end

    // ---------------- bus tasks ----------------
    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        en = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        en = 1'b0;
        d = rdata;
    endtask

    task automatic wr_ready(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        while (m_bcnt != 0) @(negedge clk);
        en = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        en = 1'b0; wr = 1'b0;
    endtask

    task automatic wr_in_busy(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        while (m_bcnt == 0) @(negedge clk);
        en = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        en = 1'b0; wr = 1'b0;
    endtask

    task automatic wait_irq(input int max_cyc);
        int n = 0;
        while (!irq && n < max_cyc) begin
            @(negedge clk);
            n++;
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [31:0] d, s, exp_sh, tgt;
        int ones;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        rd(8'h04, d); check("R12 busy after reset", d, 0);
        rd(8'h08, d); check("R12 seconds after reset", d, 0);
        rd(8'h0C, d); check("R12 shadow after reset", d, 0);
        rd(8'h14, d); check("R12 alarm0 after reset", d, 0);
        rd(8'h28, d); check("R12 mask after reset", d, 0);
        rd(8'h2C, d); check("R12 status after reset", d, 0);
        check("R12 irq after reset", {31'd0, irq}, 0);
        check("R12 wr_reject after reset", {31'd0, rej}, 0);

        // R11 mask bits
        wr_ready(8'h28, 32'hFFFF_FFFF);
        rd(8'h28, d); check("R11 mask readback", d, 32'h1F);
        wr_ready(8'h28, 32'h0);

        // R4 seconds load, R3 shadow coherence
        wr_ready(8'h08, 32'd100);
        repeat (60) @(negedge clk);
        rd(8'h10, d);
        check("R1 ms below limit", (d < MPS) ? 1 : 0, 1);
        exp_sh = m_shadow;
        rd(8'h0C, s);
        check("R3 shadow matches posted seconds", s, exp_sh);
        check("R4 seconds loaded", (s == 100 || s == 101) ? 1 : 0, 1);

        // R1 seconds advance over time
        repeat (200) @(negedge clk);
        rd(8'h08, d);
        check("R1 seconds advanced", (d >= 103 && d <= 105) ? 1 : 0, 1);

        // R2 busy window length over one full period
        @(negedge clk);
        en = 1'b1; wr = 1'b0; addr = 8'h04;
        ones = 0;
        for (int k = 0; k < GAP * PT; k++) begin
            @(negedge clk);
            ones += int'(rdata[0]);
        end
        en = 1'b0;
        check("R2 busy high cycles per period", ones, BC);

        // R5 write during busy is ignored and flagged
        wr_in_busy(8'h14, 32'd7);
        rd(8'h14, d); check("R5 alarm0 unchanged by busy write", d, 0);
        check("R5 wr_reject set", {31'd0, rej}, 1);

        // R6 alarm0
        wr_ready(8'h28, 32'h1);
        tgt = m_sec + 2;
        wr_ready(8'h14, tgt);
        check("R6 irq low before match", {31'd0, irq}, 0);
        wait_irq(400);
        check("R6 alarm0 raises irq", {31'd0, irq}, 1);
        rd(8'h2C, d); check("R6 status bit0", d, 32'h1);
        wr_ready(8'h14, 32'd0);
        wr_ready(8'h2C, 32'hFFFF_FFFF);
        rd(8'h2C, d); check("R9 clear all status", d, 0);
        check("R9 irq low after clear", {31'd0, irq}, 0);
        repeat (150) @(negedge clk);
        rd(8'h2C, d); check("R6 zero alarm disables", d, 0);

        // R7 alarm1
        wr_ready(8'h28, 32'h2);
        tgt = m_sec + 2;
        wr_ready(8'h18, tgt);
        wait_irq(400);
        check("R7 alarm1 raises irq", {31'd0, irq}, 1);
        rd(8'h2C, d); check("R7 status bit1", d, 32'h2);
        wr_ready(8'h18, 32'd0);
        wr_ready(8'h2C, 32'h2);
        rd(8'h2C, d); check("R9 clear bit1", d, 0);

        // R8 ms alarm, R10 masking
        wr_ready(8'h28, 32'h4);
        wr_ready(8'h1C, 32'd5);
        wait_irq(200);
        check("R8 ms alarm raises irq", {31'd0, irq}, 1);
        rd(8'h2C, d); check("R8 status bit2", d & 32'h4, 32'h4);
        wr_ready(8'h28, 32'h0);
        check("R10 irq low when masked", {31'd0, irq}, 0);
        rd(8'h2C, d); check("R10 status kept while masked", d & 32'h4, 32'h4);
        wr_ready(8'h1C, 32'd0);
        wr_ready(8'h2C, 32'h4);
        rd(8'h2C, d); check("R9 clear bit2", d, 0);

        // R13 read-only and unmapped offsets
        exp_sh = m_pms;
        wr_ready(8'h10, 32'h55);
        rd(8'h10, d); check("R13 write to ms register ignored", d, m_rdata);
        rd(8'h40, d); check("R13 unmapped reads zero", d, 0);

        // R11 reserved status bits
        wr_ready(8'h28, 32'h18);
        repeat (100) @(negedge clk);
        check("R11 reserved bits give no irq", {31'd0, irq}, 0);
        rd(8'h2C, d); check("R11 status bits 3,4 read zero", d & 32'h18, 0);

        repeat (5) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule